// File: doc/BRIEF.md
# I2C Bit-Level Bus Engine

This block is the bottom layer of an I2C master. A sequencer above it issues one command at a time: start, repeated start, stop, send a byte and check the acknowledge, receive a byte, or clock out one acknowledge bit. The engine turns each command into a fixed list of (SCL, SDA) level pairs. It holds each pair for a whole number of system ticks before it applies the next one.

The hold time per pair comes from the bus speed class on `speed_khz_i`, which the engine latches when it accepts a command. Both lines are open drain. An output-enable of 1 pulls the line low, and an enable of 0 releases it to the pull-up. When the last pair of a command has been held, the engine raises a one-cycle done pulse. It then presents the received byte, or the acknowledge status, on its outputs. Clock stretching, arbitration and slave operation are outside this block.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both output enables are 0 (lines released), `busy_o` and `done_o` are 0, and `rx_data_o` and `nack_o` are 0.
- R2: Command code 1 (start) produces the line pairs (SCL,SDA) = (1,1), (1,0), (0,0), in that order.
- R3: Command code 2 (repeated start) produces (0,1), (1,1), (1,0), (0,0).
- R4: Command code 3 (stop) produces (0,0), (1,0), (1,1).
- R5: Command code 4 (transmit) sends `tx_data_i` MSB first. Each bit produces (0,b), (1,b), (0,b). SDA changes only while SCL is low and was low in the previous cycle.
- R6: After the eighth bit, a transmit command produces (0,1), (1,1), (0,1). SDA is sampled in the last cycle of the (1,1) pair, and `nack_o` takes that level (0 = acknowledged, 1 = not acknowledged).
- R7: Command code 5 (receive) produces (0,1) and then eight pulses of (1,1), (0,1). SDA is sampled in the last cycle of each high pair and shifted into `rx_data_o` MSB first.
- R8: Command code 6 (acknowledge out) produces (0,a), (1,a), (0,a), where a = `ack_bit_i`.
- R9: Each pair is held for T cycles: T = 1 if `speed_khz_i` >= 1000, T = 3 if it is >= 400, and T = 10 otherwise.
- R10: `busy_o` is 1 for exactly (pairs × T) cycles, starting in the cycle after acceptance. `done_o` is then 1 for one cycle, and the lines hold their final levels.
- R11: While `busy_o` is 1, `cmd_valid_i` and changes of `speed_khz_i` have no effect on the sequence in progress or on its timing.
- R12: The output-enable ports are the inverse of the line levels. A level of 0 drives the enable to 1, and a level of 1 sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_i | input | 3 | Command code: 1 start, 2 repeated start, 3 stop, 4 transmit, 5 receive, 6 acknowledge out |
| tx_data_i | input | 8 | Byte to transmit |
| ack_bit_i | input | 1 | Bit level for acknowledge out |
| speed_khz_i | input | 11 | Bus speed class in kHz |
| sda_i | input | 1 | Level sensed on the SDA line |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse when a command completes |
| rx_data_o | output | 8 | Last received byte |
| nack_o | output | 1 | Acknowledge level from the last transmit |

## Verification
A wrong step index or phase decode shows at the line enables in the first affected pair. Because every pair is checked cycle by cycle, the error is reported at most T cycles after it occurs. A hold counter that loads a wrong value changes the width of every pair, so the first pair of a command already exposes it. A sample taken in the wrong phase or cycle shows up in `rx_data_o` or `nack_o` when `done_o` rises. The bench drives the slave's bits so that they change only on SCL falls, which makes any off-by-one in the shift order visible.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned TX_STEPS = 3 * DATA_W + 3;
  localparam int unsigned RX_STEPS = 2 * DATA_W + 1;
  localparam int unsigned STEP_W = $clog2(TX_STEPS);

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_START  = 3'd1,
    CMD_RSTART = 3'd2,
    CMD_STOP   = 3'd3,
    CMD_TX     = 3'd4,
    CMD_RX     = 3'd5,
    CMD_ACK    = 3'd6
  } cmd_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic sample;
    logic last;
  } phase_t;
endpackage

// File: rtl/i2c_speed_sel.sv
module i2c_speed_sel #(
  parameter int unsigned SPD_W   = 11,
  parameter int unsigned TICK_W  = 4,
  parameter int unsigned FP_KHZ  = 1000,
  parameter int unsigned FM_KHZ  = 400,
  parameter int unsigned FP_TICK = 1,
  parameter int unsigned FM_TICK = 3,
  parameter int unsigned SM_TICK = 10
) (
  input  logic [SPD_W-1:0]  speed_khz_i,
  output logic [TICK_W-1:0] ticks_o
);
  always_comb begin
    if (32'(speed_khz_i) >= FP_KHZ)      ticks_o = TICK_W'(FP_TICK);
    else if (32'(speed_khz_i) >= FM_KHZ) ticks_o = TICK_W'(FM_TICK);
    else                                 ticks_o = TICK_W'(SM_TICK);
  end
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int unsigned TICK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TICK_W-1:0] ticks_i,
  output logic              expire_o
);
  logic [TICK_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= ticks_i - TICK_W'(1);
      lim_q <= ticks_i - TICK_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TICK_W'(1);
    end
  end

  assign expire_o = (cnt_q == '0);

  // R9
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - TICK_W'(1));
  // R9
  cnt_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
endmodule

// File: rtl/i2c_phase_decode.sv
module i2c_phase_decode
  import i2c_bit_pkg::*;
(
  input  cmd_e              cmd_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              ack_bit_i,
  output phase_t            ph_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [STEP_W-1:0] DATA_STEPS = STEP_W'(3 * DATA_W);

  logic [STEP_W-1:0] q3, r3;
  logic [IDX_W-1:0]  bit_ix;

  always_comb begin
    q3     = step_i / STEP_W'(3);
    r3     = step_i - q3 * STEP_W'(3);
    bit_ix = IDX_W'(DATA_W - 1) - IDX_W'(q3);
    ph_o   = '{scl: 1'b1, sda: 1'b1, sample: 1'b0, last: 1'b0};
    unique case (cmd_i)
      CMD_START: begin
        ph_o.scl  = (step_i != STEP_W'(2));
        ph_o.sda  = (step_i == '0);
        ph_o.last = (step_i == STEP_W'(2));
      end
      CMD_RSTART: begin
        ph_o.scl  = (step_i == STEP_W'(1)) || (step_i == STEP_W'(2));
        ph_o.sda  = (step_i <= STEP_W'(1));
        ph_o.last = (step_i == STEP_W'(3));
      end
      CMD_STOP: begin
        ph_o.scl  = (step_i != '0);
        ph_o.sda  = (step_i == STEP_W'(2));
        ph_o.last = (step_i == STEP_W'(2));
      end
      CMD_TX: begin
        if (step_i < DATA_STEPS) begin
          ph_o.scl = (r3 == STEP_W'(1));
          ph_o.sda = tx_i[bit_ix];
        end else begin
          // acknowledge slot: release SDA, sample on high phase
          ph_o.scl    = (step_i == DATA_STEPS + STEP_W'(1));
          ph_o.sda    = 1'b1;
          ph_o.sample = (step_i == DATA_STEPS + STEP_W'(1));
          ph_o.last   = (step_i == DATA_STEPS + STEP_W'(2));
        end
      end
      CMD_RX: begin
        ph_o.scl    = step_i[0];
        ph_o.sda    = 1'b1;
        ph_o.sample = step_i[0];
        ph_o.last   = (step_i == STEP_W'(RX_STEPS - 1));
      end
      CMD_ACK: begin
        ph_o.scl  = (step_i == STEP_W'(1));
        ph_o.sda  = ack_bit_i;
        ph_o.last = (step_i == STEP_W'(2));
      end
      default: ph_o.last = 1'b1;
    endcase
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int unsigned SPD_W  = 11,
  parameter int unsigned TICK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              ack_bit_i,
  input  logic [SPD_W-1:0]  speed_khz_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              nack_o
);
  logic              busy_q, done_q, ack_q, nack_q;
  cmd_e              cmd_q;
  logic [STEP_W-1:0] step_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [TICK_W-1:0] ticks_q, ticks_in;
  phase_t            ph_q, nxt_ph;
  logic              accept, expire, advance, load;

  cmd_e              d_cmd;
  logic [STEP_W-1:0] d_step;
  logic [DATA_W-1:0] d_tx;
  logic              d_ack;

  assign accept  = cmd_valid_i && !busy_q && (cmd_i != 3'd0) && (cmd_i != 3'd7);
  assign advance = busy_q && expire;
  assign load    = accept || (advance && !ph_q.last);

  always_comb begin
    d_cmd  = busy_q ? cmd_q : cmd_e'(cmd_i);
    d_step = busy_q ? step_q + STEP_W'(1) : '0;
    d_tx   = busy_q ? tx_q : tx_data_i;
    d_ack  = busy_q ? ack_q : ack_bit_i;
  end

  i2c_speed_sel #(.SPD_W(SPD_W), .TICK_W(TICK_W)) u_speed (
    .speed_khz_i(speed_khz_i),
    .ticks_o    (ticks_in)
  );

  i2c_phase_timer #(.TICK_W(TICK_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .ticks_i (accept ? ticks_in : ticks_q),
    .expire_o(expire)
  );

  i2c_phase_decode u_decode (
    .cmd_i    (d_cmd),
    .step_i   (d_step),
    .tx_i     (d_tx),
    .ack_bit_i(d_ack),
    .ph_o     (nxt_ph)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cmd_q   <= CMD_NONE;
      step_q  <= '0;
      tx_q    <= '0;
      ack_q   <= 1'b1;
      ticks_q <= '0;
      ph_q    <= '{scl: 1'b1, sda: 1'b1, sample: 1'b0, last: 1'b0};
      rx_q    <= '0;
      nack_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        cmd_q   <= cmd_e'(cmd_i);
        tx_q    <= tx_data_i;
        ack_q   <= ack_bit_i;
        ticks_q <= ticks_in;
        step_q  <= '0;
        ph_q    <= nxt_ph;
      end else if (advance) begin
        if (ph_q.sample) begin
          if (cmd_q == CMD_TX) nack_q <= sda_i;
          if (cmd_q == CMD_RX) rx_q   <= {rx_q[DATA_W-2:0], sda_i};
        end
        if (ph_q.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= d_step;
          ph_q   <= nxt_ph;
        end
      end
    end
  end

  assign scl_oe_o  = ~ph_q.scl;
  assign sda_oe_o  = ~ph_q.sda;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_data_o = rx_q;
  assign nack_o    = nack_q;

  // R10
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  sda_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) && (cmd_q == CMD_TX || cmd_q == CMD_RX || cmd_q == CMD_ACK)
      && (sda_oe_o != $past(sda_oe_o)) |-> scl_oe_o && $past(scl_oe_o));
  // R11
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(cmd_q) && $stable(ticks_q) && $stable(tx_q));
  // R10
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !$past(busy_o) && !$past(accept) |-> $stable(scl_oe_o) && $stable(sda_oe_o));
endmodule

// File: tb/i2c_bit_engine_bench.sv
module i2c_bit_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] tx_data = 8'h00;
  logic       ack_bit = 1'b1;
  logic [10:0] speed = 11'd100;
  logic       sda_in, scl_oe, sda_oe, busy, done, nack;
  logic [7:0] rx_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // slave model
  bit       rx_mode = 1'b0;
  bit       ack_low = 1'b0;
  bit [7:0] rx_pat = 8'h00;
  int       sidx = 0;
  logic     slave_low;
  logic     scl_line;

  assign scl_line  = ~scl_oe;
  assign slave_low = (rx_mode && sidx < 8) ? ~rx_pat[7 - sidx] : (!rx_mode && ack_low);
  assign sda_in    = ~sda_oe & ~slave_low;

  always @(negedge scl_line or negedge rx_mode) begin
    if (!rx_mode) sidx = 0;
    else sidx = sidx + 1;
  end

  always #4 clk = ~clk;

  i2c_bit_engine u_i2c_bit_engine (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .tx_data_i(tx_data), .ack_bit_i(ack_bit), .speed_khz_i(speed), .sda_i(sda_in),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
    .rx_data_o(rx_data), .nack_o(nack)
  );

  logic [1:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ticks_for(input int spd);
    if (spd >= 1000) return 1;
    if (spd >= 400) return 3;
    return 10;
  endfunction

  task automatic push_pair(input bit s_cl, input bit s_da, input int t, input string tag);
    for (int i = 0; i < t; i++) begin
      exp_q.push_back({s_cl, s_da});
      tag_q.push_back(tag);
    end
  endtask

  // monitor: compares driven levels per cycle
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 busy beyond expected length", 1, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({~scl_oe, ~sda_oe} == e, t, {~scl_oe, ~sda_oe}, e);
      end
    end
  end

  task automatic run(input int c, input bit [7:0] d, input bit a, input int spd, input bit poke);
    int t;
    string tg;
    t = ticks_for(spd);
    case (c)
      1: begin tg = "R2 start"; push_pair(1,1,t,tg); push_pair(1,0,t,tg); push_pair(0,0,t,tg); end
      2: begin tg = "R3 rstart"; push_pair(0,1,t,tg); push_pair(1,1,t,tg); push_pair(1,0,t,tg); push_pair(0,0,t,tg); end
      3: begin tg = "R4 stop"; push_pair(0,0,t,tg); push_pair(1,0,t,tg); push_pair(1,1,t,tg); end
      4: begin
        tg = poke ? "R11 tx while poked" : "R5 tx bit";
        for (int b = 7; b >= 0; b--) begin
          push_pair(0,d[b],t,tg); push_pair(1,d[b],t,tg); push_pair(0,d[b],t,tg);
        end
        push_pair(0,1,t,"R6 ack slot"); push_pair(1,1,t,"R6 ack slot"); push_pair(0,1,t,"R6 ack slot");
      end
      5: begin
        tg = "R7 rx";
        push_pair(0,1,t,tg);
        for (int b = 0; b < 8; b++) begin push_pair(1,1,t,tg); push_pair(0,1,t,tg); end
      end
      default: begin tg = "R8 ackout"; push_pair(0,a,t,tg); push_pair(1,a,t,tg); push_pair(0,a,t,tg); end
    endcase
    @(negedge clk);
    cmd = 3'(c); tx_data = d; ack_bit = a; speed = 11'(spd); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 3'd0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      cmd = 3'd3; cmd_valid = 1'b1; speed = 11'd1000; tx_data = ~d;
      repeat (2) @(negedge clk);
      cmd_valid = 1'b0; cmd = 3'd0;
    end
    while (!done) @(negedge clk);
    chk(exp_q.size() == 0, "R10 sequence length", exp_q.size(), 0);
    chk(scl_oe == ~exp_last_scl(c) , "R10 lines hold at done", scl_oe, ~exp_last_scl(c));
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
  endtask

  function automatic bit exp_last_scl(input int c);
    return (c == 3);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 R12 lines released", {scl_oe, sda_oe}, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle flags", {busy, done}, 0);
    chk(rx_data == 8'h00 && nack == 1'b0, "R1 result regs", {nack, rx_data}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(1, 8'h00, 1'b1, 100, 1'b0);
    ack_low = 1'b1;
    run(4, 8'hA5, 1'b1, 100, 1'b0);
    chk(nack == 1'b0, "R6 ack low -> nack 0", nack, 0);
    ack_low = 1'b0;
    run(4, 8'h3C, 1'b1, 400, 1'b0);
    chk(nack == 1'b1, "R6 ack high -> nack 1", nack, 1);
    run(2, 8'h00, 1'b1, 1000, 1'b0);

    rx_pat = 8'h96; rx_mode = 1'b1;
    run(5, 8'h00, 1'b1, 400, 1'b0);
    rx_mode = 1'b0;
    chk(rx_data == 8'h96, "R7 rx byte 96", rx_data, 8'h96);
    run(6, 8'h00, 1'b0, 400, 1'b0);

    rx_pat = 8'h5A; rx_mode = 1'b1;
    run(5, 8'h00, 1'b1, 1000, 1'b0);
    rx_mode = 1'b0;
    chk(rx_data == 8'h5A, "R7 rx byte 5A", rx_data, 8'h5A);
    run(6, 8'h00, 1'b1, 1000, 1'b0);

    // R11: ignored command and speed change mid-transfer
    ack_low = 1'b1;
    run(4, 8'h81, 1'b1, 400, 1'b1);
    chk(nack == 1'b0, "R11 tx result after poke", nack, 0);
    ack_low = 1'b0;

    // R9 threshold edges
    run(1, 8'h00, 1'b1, 399, 1'b0);
    run(3, 8'h00, 1'b1, 400, 1'b0);
    run(1, 8'h00, 1'b1, 999, 1'b0);
    run(3, 8'h00, 1'b1, 1000, 1'b0);
    run(3, 8'h00, 1'b1, 2000, 1'b0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R12 released after stop", {scl_oe, sda_oe}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule